// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. It accepts five request sources: two active-low external pins, two timer overflow flags and one serial port flag. It presents at most one request to the core, together with a 3-bit source number and a 16-bit service address. A per-source enable mask and a global enable gate the sources. A per-source priority mask places each source in the low or the high class. Each external pin can be set for level sensing or for falling-edge capture.

A small state machine records which priority classes are in service. It has four states. ST_IDLE means nothing is in service. ST_LOW means a low-class routine is running. ST_HIGH means a high-class routine is running. ST_NEST means a high-class routine has preempted a low-class one.

The transitions are as follows. From ST_IDLE, an accepted low-class request moves to ST_LOW and an accepted high-class request moves to ST_HIGH. From ST_LOW, an accepted high-class request moves to ST_NEST and a return pulse moves back to ST_IDLE. From ST_HIGH, a return pulse moves to ST_IDLE. From ST_NEST, a return pulse moves to ST_LOW.

The core accepts the offered request with a one-cycle acknowledge. It signals the end of a routine with a one-cycle return pulse.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0 and `act_lvl` is 2'b00. In `act_lvl`, bit 1 means a high-class routine is in service and bit 0 means a low-class routine is in service.
- R2: A source can raise `irq_req` only while `glb_en` is 1 and its own bit of `src_en` is 1. The source numbers are ext pin 0 = 0, timer 0 = 1, ext pin 1 = 2, timer 1 = 3, serial = 4, and these numbers are the bit positions in `src_en`, `src_hi` and `irq_id`.
- R3: When several sources of the same class are pending, `irq_id` shows the lowest source number among them.
- R4: A pending source whose `src_hi` bit is 1 is offered ahead of every low-class source, whatever their numbers, and `irq_hi` is then 1.
- R5: `irq_vec` equals 0x0003 + 8 × `irq_id`.
- R6: With `edge_sel[k]` = 0, ext pin k requests in the same cycle its input is low, and stops requesting in the same cycle its input returns high.
- R7: With `edge_sel[k]` = 1, a falling edge on ext pin k is captured at the next rising clock edge. The capture stays pending after the pin returns high. It is cleared when the core acknowledges that source.
- R8: An acknowledge while `irq_req` is 1 sets the in-service bit of the offered class. The moves are 00→01 for a low-class request, 00→10 for a high-class request, and 01→11 for a high-class request.
- R9: While only the low class is in service, only high-class requests are offered. While the high class is in service (`act_lvl` 10 or 11), no request is offered.
- R10: A return pulse clears the highest set in-service bit (11→01, 10→00, 01→00). It has no effect in 00. It takes precedence over an acknowledge in the same cycle.
- R11: An acknowledge while `irq_req` is 0 leaves `act_lvl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_n | input | 2 | Active-low external request pins |
| tmr_ovf | input | 2 | Timer overflow request flags |
| ser_flag | input | 1 | Serial port request flag |
| glb_en | input | 1 | Global enable |
| src_en | input | 5 | Per-source enable mask |
| src_hi | input | 5 | Per-source class select, 1 = high |
| edge_sel | input | 2 | Per-pin sensing, 1 = falling edge, 0 = level |
| irq_ack | input | 1 | Core accepts the offered request |
| reti | input | 1 | Core returns from a routine |
| irq_req | output | 1 | Request offered to the core |
| irq_hi | output | 1 | Offered request belongs to the high class |
| irq_id | output | 3 | Source number of the offered request |
| irq_vec | output | 16 | Service address of the offered request |
| act_lvl | output | 2 | In-service bits {high, low} |

## Verification
The request outputs (`irq_req`, `irq_hi`, `irq_id`, `irq_vec`) are combinational in the inputs and the service state. The bench therefore checks them a moment after driving the inputs, within the same cycle.

Three results are registered and become visible only after one rising edge:
- an edge-mode capture;
- an in-service change after an acknowledge;
- an in-service change after a return pulse.

For these, the bench drives the stimulus just after an edge, crosses one rising edge, and then samples. For edge mode, it also samples before that edge to confirm that the request is not yet present.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC     = 5;
    localparam int NPIN     = 2;
    localparam int ID_W     = $clog2(NSRC);
    localparam int VEC_W    = 16;
    localparam int VEC_SHFT = 3;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_NEST = 2'd3
    } svc_state_t;
endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic taken,
    output logic req
);
    logic pin_q;
    logic cap_q;
    logic fall;

    assign fall = pin_q & ~pin_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
            cap_q <= 1'b0;
        end else begin
            pin_q <= pin_n;
            if (!edge_mode)
                cap_q <= 1'b0;
            else if (fall)
                cap_q <= 1'b1;
            else if (taken)
                cap_q <= 1'b0;
        end
    end

    assign req = edge_mode ? cap_q : ~pin_n;
endmodule

// File: rtl/irq_poll.sv
module irq_poll #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  hi_pend,
    input  logic [N-1:0]  lo_pend,
    output logic          hi_any,
    output logic          lo_any,
    output logic [IW-1:0] hi_id,
    output logic [IW-1:0] lo_id
);
    always_comb begin
        hi_id = '0;
        lo_id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hi_pend[i]) hi_id = IW'(i);
            if (lo_pend[i]) lo_id = IW'(i);
        end
    end

    assign hi_any = |hi_pend;
    assign lo_any = |lo_pend;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPIN-1:0]       ext_n,
    input  logic [1:0]            tmr_ovf,
    input  logic                  ser_flag,
    input  logic                  glb_en,
    input  logic [NSRC-1:0]       src_en,
    input  logic [NSRC-1:0]       src_hi,
    input  logic [NPIN-1:0]       edge_sel,
    input  logic                  irq_ack,
    input  logic                  reti,
    output logic                  irq_req,
    output logic                  irq_hi,
    output logic [ID_W-1:0]       irq_id,
    output logic [VEC_W-1:0]      irq_vec,
    output logic [1:0]            act_lvl
);
    localparam int PAD_W = VEC_W - ID_W - VEC_SHFT;

    svc_state_t state, state_nx;
    logic [NPIN-1:0] pin_req;
    logic [NSRC-1:0] raw, pend;
    logic hi_any, lo_any, hi_ok, lo_ok, take;
    logic [ID_W-1:0] hi_id, lo_id;

    // ext pins occupy source numbers 0 and 2
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        irq_pin_cond u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[g]),
            .edge_mode (edge_sel[g]),
            .taken     (take && (irq_id == ID_W'(2 * g))),
            .req       (pin_req[g])
        );
    end

    assign raw  = {ser_flag, tmr_ovf[1], pin_req[1], tmr_ovf[0], pin_req[0]};
    assign pend = raw & src_en & {NSRC{glb_en}};

    irq_poll #(.N(NSRC), .IW(ID_W)) u_poll (
        .hi_pend (pend & src_hi),
        .lo_pend (pend & ~src_hi),
        .hi_any  (hi_any),
        .lo_any  (lo_any),
        .hi_id   (hi_id),
        .lo_id   (lo_id)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign take = irq_ack & irq_req & ~reti;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (take) state_nx = irq_hi ? ST_HIGH : ST_LOW;
            ST_LOW:  if (reti) state_nx = ST_IDLE;
                     else if (take) state_nx = ST_NEST;
            ST_HIGH: if (reti) state_nx = ST_IDLE;
            ST_NEST: if (reti) state_nx = ST_LOW;
        endcase
    end

    always_comb begin
        hi_ok   = 1'b0;
        lo_ok   = 1'b0;
        act_lvl = 2'b00;
        unique case (state)
            ST_IDLE: begin hi_ok = 1'b1; lo_ok = 1'b1; end
            ST_LOW:  begin hi_ok = 1'b1; act_lvl = 2'b01; end
            ST_HIGH: act_lvl = 2'b10;
            ST_NEST: act_lvl = 2'b11;
        endcase
    end

    assign irq_hi  = hi_any;
    assign irq_id  = hi_any ? hi_id : lo_id;
    assign irq_req = (hi_any & hi_ok) | (~hi_any & lo_any & lo_ok);
    assign irq_vec = VEC_BASE + {{PAD_W{1'b0}}, irq_id, {VEC_SHFT{1'b0}}};
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            glb_en,
    input logic [NSRC-1:0] src_en,
    input logic            irq_ack,
    input logic            reti,
    input logic            irq_req,
    input logic            irq_hi,
    input logic [ID_W-1:0] irq_id,
    input logic [1:0]      act_lvl
);
    AST_REQ_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> glb_en); // R2
    AST_REQ_SRC_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> src_en[irq_id]); // R2
    AST_HIGH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        act_lvl[1] |-> !irq_req); // R9
    AST_LOW_ONLY_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (act_lvl == 2'b01 && irq_req) |-> irq_hi); // R9
    AST_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !reti && irq_req && irq_hi && act_lvl == 2'b00) |=> act_lvl == 2'b10); // R8
    AST_NEST_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && act_lvl == 2'b11) |=> act_lvl == 2'b01); // R10
    AST_IDLE_RET: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && act_lvl == 2'b00) |=> act_lvl == 2'b00); // R10
    AST_NOREQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !reti && !irq_req) |=> $stable(act_lvl)); // R11
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .glb_en  (glb_en),
    .src_en  (src_en),
    .irq_ack (irq_ack),
    .reti    (reti),
    .irq_req (irq_req),
    .irq_hi  (irq_hi),
    .irq_id  (irq_id),
    .act_lvl (act_lvl)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  tmr_ovf = '0;
    logic        ser_flag = 1'b0;
    logic        glb_en = 1'b0;
    logic [4:0]  src_en = '0;
    logic [4:0]  src_hi = '0;
    logic [1:0]  edge_sel = '0;
    logic        irq_ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq_req, irq_hi;
    logic [2:0]  irq_id;
    logic [15:0] irq_vec;
    logic [1:0]  act_lvl;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_n(ext_n), .tmr_ovf(tmr_ovf),
        .ser_flag(ser_flag), .glb_en(glb_en), .src_en(src_en),
        .src_hi(src_hi), .edge_sel(edge_sel), .irq_ack(irq_ack),
        .reti(reti), .irq_req(irq_req), .irq_hi(irq_hi), .irq_id(irq_id),
        .irq_vec(irq_vec), .act_lvl(act_lvl)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic quiet();
        ext_n = 2'b11; tmr_ovf = '0; ser_flag = 1'b0;
        irq_ack = 1'b0; reti = 1'b0; edge_sel = '0; src_hi = '0;
        glb_en = 1'b1; src_en = 5'h1F;
        settle();
    endtask

    task automatic ack_once();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0; settle();
    endtask

    task automatic ret_once();
        reti = 1'b1; tick(); reti = 1'b0; settle();
    endtask

    task automatic t_reset();
        settle();
        chk(irq_req, 0, "R1 req after reset");
        chk(act_lvl, 0, "R1 act_lvl after reset");
    endtask

    task automatic t_enable();
        quiet();
        tmr_ovf[0] = 1'b1; glb_en = 1'b0; settle();
        chk(irq_req, 0, "R2 global enable off");
        glb_en = 1'b1; src_en = 5'b11101; settle();
        chk(irq_req, 0, "R2 source enable off");
        src_en = 5'h1F; settle();
        chk(irq_req, 1, "R2 both enables on");
        chk(irq_id, 1, "R2 id timer0");
        chk(irq_vec, 16'h000B, "R5 vector timer0");
    endtask

    task automatic t_order();
        quiet();
        tmr_ovf = 2'b11; ser_flag = 1'b1; settle();
        chk(irq_id, 1, "R3 lowest id wins");
        src_en = 5'b11101; settle();
        chk(irq_id, 3, "R3 next in order");
        chk(irq_vec, 16'h001B, "R5 vector timer1");
        tmr_ovf = 2'b00; settle();
        chk(irq_vec, 16'h0023, "R5 vector serial");
    endtask

    task automatic t_prio();
        quiet();
        tmr_ovf[0] = 1'b1; ser_flag = 1'b1; src_hi = 5'b10000; settle();
        chk(irq_id, 4, "R4 high class first");
        chk(irq_hi, 1, "R4 irq_hi");
    endtask

    task automatic t_level();
        quiet();
        ext_n[0] = 1'b0; settle();
        chk(irq_req, 1, "R6 level low requests");
        chk(irq_vec, 16'h0003, "R5 vector ext0");
        ext_n[0] = 1'b1; settle();
        chk(irq_req, 0, "R6 level released");
    endtask

    task automatic t_edge();
        quiet();
        edge_sel[1] = 1'b1; tick();
        ext_n[1] = 1'b0; settle();
        chk(irq_req, 0, "R7 not before edge");
        tick();
        chk(irq_req, 1, "R7 captured");
        chk(irq_id, 2, "R7 id ext1");
        ext_n[1] = 1'b1; tick();
        chk(irq_req, 1, "R7 held after release");
        ack_once();
        chk(act_lvl, 2'b01, "R8 low ack");
        ret_once();
        chk(act_lvl, 2'b00, "R10 low return");
        chk(irq_req, 0, "R7 cleared by ack");
    endtask

    task automatic t_nest();
        quiet();
        src_hi = 5'b10000; tmr_ovf[0] = 1'b1; settle();
        ack_once();
        chk(act_lvl, 2'b01, "R8 00 to 01");
        chk(irq_req, 0, "R9 low blocked in low service");
        ser_flag = 1'b1; settle();
        chk(irq_req, 1, "R9 high offered in low service");
        ack_once();
        chk(act_lvl, 2'b11, "R8 01 to 11");
        chk(irq_req, 0, "R9 nothing in high service");
        ser_flag = 1'b0; tmr_ovf = '0;
        ret_once();
        chk(act_lvl, 2'b01, "R10 11 to 01");
        ret_once();
        chk(act_lvl, 2'b00, "R10 01 to 00");
    endtask

    task automatic t_high();
        quiet();
        src_hi = 5'b10000; ser_flag = 1'b1; settle();
        ack_once();
        chk(act_lvl, 2'b10, "R8 00 to 10");
        ser_flag = 1'b0; tmr_ovf[0] = 1'b1; settle();
        chk(irq_req, 0, "R9 low blocked in high service");
        irq_ack = 1'b1; ret_once(); irq_ack = 1'b0;
        chk(act_lvl, 2'b00, "R10 return beats ack");
        tmr_ovf = '0; settle();
        ret_once();
        chk(act_lvl, 2'b00, "R10 return in idle");
        ack_once();
        chk(act_lvl, 2'b00, "R11 ack without request");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3 + 1);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_enable();
        t_order();
        t_prio();
        t_level();
        t_edge();
        t_nest();
        t_high();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule